// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

This block is one channel of a memory-mapped interval timer. An up-counter advances once per prescaled tick while the channel's own bit in a shared run register is set. When the count equals the programmed compare value, the counter goes back to zero on that same tick and a sticky match flag is raised. One full period is therefore compare+1 ticks. An interrupt output follows the match flag whenever the interrupt enable bit is set.

Software uses the block through a small register bus with a byte address, a write strobe, write data and combinational read data. A run register at byte 0 is shared by several channels. The channel's control/status, counter and compare registers sit at a parameterised base further up. A build-time parameter picks the narrow variant (16-bit counter, 2-byte register stride) or the wide variant (32-bit counter, 4-byte stride). The variants also differ in which bits of control/status hold the flags and the interrupt enable. A write to the counter does not land at once: it takes effect on the second prescaled tick after the write.

Top module: `cmt_channel`

## Requirements
- R1: Byte offsets: the run register is at 0x00. Control/status is at CH_BASE (default 0x10), the counter at CH_BASE+stride and compare at CH_BASE+2*stride, with a stride of 2 in the narrow variant and 4 in the wide one. Any other offset reads as zero and ignores writes.
- R2: After reset the run register, control/status and counter read 0, compare reads all ones (0xFFFF narrow, 0xFFFFFFFF wide), irq is low and the counter does not advance.
- R3: The run register stores NUM_CH bits exactly as written. Only bit CH_SEL (default 1) lets the counter advance, and the other bits have no effect on this channel.
- R4: The tick is a free-running division of clk by 8*4^s, where s is control/status bits [1:0] (0 gives /8, 3 gives /512). The counter changes only on a tick and advances by one per tick while running.
- R5: On a tick with count equal to compare, the counter becomes 0 and the match flag is set, so a period lasts compare+1 ticks.
- R6: The match flag is bit 7 (narrow) or bit 15 (wide) of control/status. It is sticky, is cleared by a control/status write with that bit 0, and is left unchanged by a write with that bit 1. A match in the same cycle as a clearing write leaves it set.
- R7: If compare is below the count, the counter runs up to all ones and wraps to 0 without setting the match flag, then matches on the next pass. In the wide variant such a wrap sets bit 14 of control/status, which is cleared the same way as the match flag.
- R8: The interrupt enable is bit 6 (narrow) or bit 5 (wide). irq is high exactly while the match flag and enable are both 1, and it is low in the cycle after a write that clears the flag or writes 0 to control/status.
- R9: A counter write takes effect on the second tick after the write, even while stopped. Until then the counter reads its old value and keeps counting, and a further write restarts the two-tick wait with the new value.
- R10: A compare write keeps the low 16 bits (narrow) or all 32 bits (wide).
- R11: Control/status is 16 bits wide. Every bit other than the status bits reads back as written, e.g. 0x0043 in the narrow variant and 0x01A4 in the wide variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the prescaler divides it |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Byte offset of the register accessed |
| we | input | 1 | Write strobe, one write per cycle while high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, zero-extended, combinational |
| irq | output | 1 | Interrupt request, level high |

## Verification
The assertions assume that the bus drives at most one register write per cycle and that addr, we and wdata are steady around the clock edge. The bench drives them only at the falling edge and clears we after a single cycle. They also assume that compare, counter and run values arrive only through the bus. The stimulus therefore keeps the prescaler select at small divisions during the random phase and biases compare and counter values toward small numbers and the last values below all ones, so that matches, wraps and pending loads all happen inside the run.

// File: rtl/cmt_pkg.sv
// Package: shared types and variant-dependent constants for the
// compare-match timer channel.
// Assumes: a variant flag of 1 selects the 32-bit build, 0 the 16-bit build.
package cmt_pkg;

    // Register chosen by the byte-offset decoder
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_START = 3'd1,
        SEL_CSR   = 3'd2,
        SEL_CNT   = 3'd3,
        SEL_CMP   = 3'd4
    } reg_sel_e;

    localparam int CSR_W   = 16;
    localparam int DATA_W  = 32;
    localparam int MAX_SEL = 3;
    localparam int PRE_W   = 3 + 2 * MAX_SEL;

    // Position of the sticky match flag
    function automatic int flag_pos(input bit wide);
        return wide ? 15 : 7;
    endfunction

    // Position of the interrupt enable
    function automatic int ie_pos(input bit wide);
        return wide ? 5 : 6;
    endfunction

    // Bits of control/status that are clear-on-write-zero status
    function automatic logic [CSR_W-1:0] stat_mask(input bit wide);
        return wide ? 16'hC000 : 16'h0080;
    endfunction

endpackage

// File: rtl/cmt_regdec.sv
// Module: byte-offset decoder for the timer channel register bus.
// Assumes: offsets are exact byte addresses; the run register lives in
// the common area below CH_BASE and the channel registers are STRIDE apart.
module cmt_regdec #(
    parameter int ADDR_W    = 8,
    parameter int START_OFS = 0,
    parameter int CH_BASE   = 16,
    parameter int STRIDE    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output cmt_pkg::reg_sel_e sel
);
    import cmt_pkg::*;

    localparam logic [ADDR_W-1:0] OFS_START = ADDR_W'(START_OFS);
    localparam logic [ADDR_W-1:0] OFS_CSR   = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] OFS_CNT   = ADDR_W'(CH_BASE + STRIDE);
    localparam logic [ADDR_W-1:0] OFS_CMP   = ADDR_W'(CH_BASE + 2 * STRIDE);

    // Map the byte offset onto one register or none
    always_comb begin
        sel = SEL_NONE;
        if (addr == OFS_START)    sel = SEL_START;
        else if (addr == OFS_CSR) sel = SEL_CSR;
        else if (addr == OFS_CNT) sel = SEL_CNT;
        else if (addr == OFS_CMP) sel = SEL_CMP;
    end

endmodule

// File: rtl/cmt_prescaler.sv
// Module: free-running clock divider producing the count tick.
// Assumes: the divide ratio is 8*4^sel; a change of sel takes effect at
// the next point where the low bits of the divider are all ones.
module cmt_prescaler #(
    parameter int SEL_W   = 2,
    parameter int MAX_SEL = 3,
    parameter int PRE_W   = 3 + 2 * MAX_SEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Advance the divider every clock
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Low 3+2*sel bits all ones marks the last clock of a tick period
    always_comb begin
        mask = {PRE_W{1'b1}} >> (2 * (MAX_SEL - int'(sel)));
        tick = ((pre_q & mask) == mask);
    end

endmodule

// File: rtl/cmt_counter.sv
// Module: count register with compare match, wrap detection and a
// counter write that lands on the second tick after the bus write.
// Assumes: tick is a single-cycle pulse; wr_en is a bus write to the counter.
module cmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             load_now,
    output logic             match_set,
    output logic             wrap_set
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [1:0]       pend_q;
    logic             step;
    logic [CNT_W-1:0] cnt_next;

    // Decide load, match, wrap or plain increment for this cycle
    always_comb begin
        load_now  = tick && (pend_q == 2'd1);
        step      = tick && run && !load_now;
        match_set = step && (cnt_q == cmp);
        wrap_set  = step && (cnt_q != cmp) && (cnt_q == CNT_MAX);
        if (match_set || wrap_set) cnt_next = '0;
        else                       cnt_next = cnt_q + 1'b1;
    end

    // Hold a written value and count down the ticks before it lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_val_q <= '0;
            pend_q     <= 2'd0;
        end else if (wr_en) begin
            pend_val_q <= wr_data;
            pend_q     <= 2'd2;
        end else if (tick && (pend_q != 2'd0)) begin
            pend_q     <= pend_q - 2'd1;
        end
    end

    // Update the visible count
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load_now) cnt_q <= pend_val_q;
        else if (step)     cnt_q <= cnt_next;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/cmt_channel.sv
// Module: top of one compare-match timer channel with its register bus.
// Assumes: one bus access per cycle; WIDE=1 builds the 32-bit variant,
// WIDE=0 the 16-bit variant; CH_SEL picks this channel's run bit.
module cmt_channel #(
    parameter bit WIDE    = 1'b1,
    parameter int NUM_CH  = 4,
    parameter int CH_SEL  = 1,
    parameter int ADDR_W  = 8,
    parameter int CH_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    import cmt_pkg::*;

    localparam int CNT_W  = WIDE ? 32 : 16;
    localparam int STRIDE = WIDE ? 4 : 2;
    localparam int FLAG_B = flag_pos(WIDE);
    localparam int IE_B   = ie_pos(WIDE);
    localparam logic [CSR_W-1:0] STAT = stat_mask(WIDE);

    reg_sel_e          reg_sel;
    logic [NUM_CH-1:0] start_q;
    logic [CSR_W-1:0]  csr_q;
    logic [CSR_W-1:0]  csr_d;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cnt_val;
    logic [CSR_W-1:0]  stat_set;
    logic              tick;
    logic              load_now;
    logic              match_set;
    logic              wrap_set;
    logic              wr_cnt;

    cmt_regdec #(
        .ADDR_W   (ADDR_W),
        .START_OFS(0),
        .CH_BASE  (CH_BASE),
        .STRIDE   (STRIDE)
    ) u_dec (
        .addr(addr),
        .sel (reg_sel)
    );

    cmt_prescaler #(
        .SEL_W  (2),
        .MAX_SEL(MAX_SEL),
        .PRE_W  (PRE_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (csr_q[1:0]),
        .tick (tick)
    );

    assign wr_cnt = we && (reg_sel == SEL_CNT);

    cmt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (start_q[CH_SEL]),
        .cmp      (cmp_q),
        .wr_en    (wr_cnt),
        .wr_data  (CNT_W'(wdata)),
        .cnt      (cnt_val),
        .load_now (load_now),
        .match_set(match_set),
        .wrap_set (wrap_set)
    );

    // Route counter events onto the status bits of this variant
    generate
        if (WIDE) begin : g_wide_stat
            assign stat_set = {match_set, wrap_set, 14'd0};
        end else begin : g_narrow_stat
            assign stat_set = {8'd0, match_set, 7'd0};
        end
    endgenerate

    // Next control/status: plain bits follow the write, status bits only clear
    always_comb begin
        csr_d = csr_q;
        if (we && (reg_sel == SEL_CSR))
            csr_d = (wdata[CSR_W-1:0] & ~STAT) | (csr_q & wdata[CSR_W-1:0] & STAT);
        csr_d = csr_d | stat_set;
    end

    // Register the run bits, control/status and compare value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            csr_q   <= '0;
            cmp_q   <= '1;
        end else begin
            csr_q <= csr_d;
            if (we && (reg_sel == SEL_START)) start_q <= wdata[NUM_CH-1:0];
            if (we && (reg_sel == SEL_CMP))   cmp_q   <= CNT_W'(wdata);
        end
    end

    // Return the addressed register, zero-extended
    always_comb begin
        case (reg_sel)
            SEL_START: rdata = DATA_W'(start_q);
            SEL_CSR:   rdata = DATA_W'(csr_q);
            SEL_CNT:   rdata = DATA_W'(cnt_val);
            SEL_CMP:   rdata = DATA_W'(cmp_q);
            default:   rdata = '0;
        endcase
    end

    assign irq = csr_q[FLAG_B] && csr_q[IE_B];

endmodule

// File: rtl/cmt_channel_chk.sv
// Module: property checker for cmt_channel, attached with bind.
// Assumes: signals are sampled at the rising edge of clk; all properties
// are disabled while rst_n is low.
module cmt_channel_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_SEL = 1,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input cmt_pkg::reg_sel_e reg_sel,
    input logic              wr_flag,
    input logic [NUM_CH-1:0] wr_start,
    input logic              irq,
    input logic [NUM_CH-1:0] start_q,
    input logic              flag,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              tick,
    input logic              load_now,
    input logic              match_set
);
    import cmt_pkg::*;

    logic clr_wr;
    assign clr_wr = we && (reg_sel == SEL_CSR) && !wr_flag;

    // R5
    match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_set |=> ((cnt_val == '0) && flag));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !match_set) |=> !irq);

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q[CH_SEL] && !load_now) |=> $stable(cnt_val));

    // R4
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_val));

    // R3
    start_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (reg_sel == SEL_START)) |=> (start_q == $past(wr_start)));

endmodule

bind cmt_channel cmt_channel_chk #(
    .NUM_CH(NUM_CH),
    .CH_SEL(CH_SEL),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .reg_sel  (reg_sel),
    .wr_flag  (wdata[FLAG_B]),
    .wr_start (wdata[NUM_CH-1:0]),
    .irq      (irq),
    .start_q  (start_q),
    .flag     (csr_q[FLAG_B]),
    .cnt_val  (cnt_val),
    .tick     (tick),
    .load_now (load_now),
    .match_set(match_set)
);

// File: tb/tb_cmt_channel.sv
// Bench: drives a wide (dut) and a narrow (dut_n) channel from one bus,
// predicts every register and irq with a cycle model built from the
// requirements, and mixes directed corner cases with seeded random traffic.
module tb_cmt_channel;

    localparam int CLK_PERIOD = 10;
    localparam int CH_SEL     = 1;
    localparam int BASE       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we_w = 1'b0;
    logic        we_n = 1'b0;
    logic [31:0] rdata_w, rdata_n;
    logic        irq_w, irq_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit irq_chk_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmt_channel #(.WIDE(1'b1), .NUM_CH(4), .CH_SEL(CH_SEL), .ADDR_W(8), .CH_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we_w), .wdata(wdata),
        .rdata(rdata_w), .irq(irq_w));

    cmt_channel #(.WIDE(1'b0), .NUM_CH(4), .CH_SEL(CH_SEL), .ADDR_W(8), .CH_BASE(BASE)) dut_n (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we_n), .wdata(wdata),
        .rdata(rdata_n), .irq(irq_n));

    // ---------------- reference model, index 1 = wide, 0 = narrow
    logic [31:0] m_cnt [2];
    logic [31:0] m_cmp [2];
    logic [31:0] m_pv  [2];
    logic [15:0] m_csr [2];
    logic [3:0]  m_st  [2];
    logic [1:0]  m_pn  [2];
    logic [8:0]  m_pre [2];

    function automatic logic [31:0] f_max(input int v);
        return v ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction
    function automatic int f_stride(input int v);
        return v ? 4 : 2;
    endfunction
    function automatic int f_flag(input int v);
        return v ? 15 : 7;
    endfunction
    function automatic int f_ie(input int v);
        return v ? 5 : 6;
    endfunction
    function automatic logic [15:0] f_stat(input int v);
        return v ? 16'hC000 : 16'h0080;
    endfunction

    function automatic logic [31:0] f_read(input int v, input logic [7:0] a);
        if (a == 8'd0)                            return {28'd0, m_st[v]};
        if (a == 8'(BASE))                        return {16'd0, m_csr[v]};
        if (a == 8'(BASE + f_stride(v)))          return m_cnt[v];
        if (a == 8'(BASE + 2 * f_stride(v)))      return m_cmp[v];
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_cnt[v] = '0; m_cmp[v] = f_max(v); m_pv[v] = '0;
                m_csr[v] = '0; m_st[v] = '0; m_pn[v] = '0; m_pre[v] = '0;
            end else begin
                logic [8:0]  msk;
                logic        tk, run, ld, ms, ws, wr;
                logic [31:0] ncnt;
                logic [15:0] ncsr;
                wr   = v ? we_w : we_n;
                msk  = 9'h1FF >> (2 * (3 - int'(m_csr[v][1:0])));
                tk   = ((m_pre[v] & msk) == msk);
                run  = m_st[v][CH_SEL];
                ld   = tk && (m_pn[v] == 2'd1);
                ms   = 1'b0; ws = 1'b0;
                ncnt = m_cnt[v];
                if (ld) ncnt = m_pv[v];
                else if (tk && run) begin
                    if (m_cnt[v] == m_cmp[v]) begin ncnt = 0; ms = 1'b1; end
                    else if (m_cnt[v] == f_max(v)) begin ncnt = 0; ws = (v == 1); end
                    else ncnt = m_cnt[v] + 1;
                end
                ncsr = m_csr[v];
                if (wr && addr == 8'(BASE))
                    ncsr = (wdata[15:0] & ~f_stat(v)) | (m_csr[v] & wdata[15:0] & f_stat(v));
                if (ms) ncsr[f_flag(v)] = 1'b1;
                if (ws) ncsr[14] = 1'b1;
                if (wr && addr == 8'(BASE + f_stride(v))) begin
                    m_pv[v] = wdata & f_max(v); m_pn[v] = 2'd2;
                end else if (tk && m_pn[v] != 2'd0) m_pn[v] = m_pn[v] - 2'd1;
                if (wr && addr == 8'd0) m_st[v] = wdata[3:0];
                if (wr && addr == 8'(BASE + 2 * f_stride(v))) m_cmp[v] = wdata & f_max(v);
                m_cnt[v] = ncnt;
                m_csr[v] = ncsr;
                m_pre[v] = m_pre[v] + 1;
            end
        end
    end

    // ---------------- checks
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    // irq of both variants against the model every falling edge (R8)
    always @(negedge clk) begin
        if (irq_chk_on) begin
            chk("R8 irq wide",   {31'd0, irq_w}, {31'd0, m_csr[1][15] & m_csr[1][5]});
            chk("R8 irq narrow", {31'd0, irq_n}, {31'd0, m_csr[0][7] & m_csr[0][6]});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // tasks start just after a falling edge and end at the next one
    task automatic wr(input int v, input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d;
        if (v == 1) we_w = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        we_w = 1'b0; we_n = 1'b0;
    endtask

    task automatic rd_chk(input int v, input logic [7:0] a, input string tag);
        logic [31:0] got;
        addr = a; we_w = 1'b0; we_n = 1'b0;
        #1;
        got = v ? rdata_w : rdata_n;
        chk(tag, got, f_read(v, a));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input int v, input logic [7:0] a);
        if (a == 8'd0)                       return "R3 run reg";
        if (a == 8'(BASE))                   return "R6 ctrl/status";
        if (a == 8'(BASE + f_stride(v)))     return "R9 counter";
        if (a == 8'(BASE + 2 * f_stride(v))) return "R10 compare";
        return "R1 unmapped";
    endfunction

    initial begin
        logic [7:0] ofs_w_cnt, ofs_w_cmp, ofs_n_cnt, ofs_n_cmp;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        ofs_w_cnt = 8'(BASE + 4); ofs_w_cmp = 8'(BASE + 8);
        ofs_n_cnt = 8'(BASE + 2); ofs_n_cmp = 8'(BASE + 4);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        irq_chk_on = 1'b1;

        // R2: reset values, literal expectations
        addr = 8'd0; #1; chk("R2 run reg reset", rdata_w, 32'd0); @(negedge clk);
        addr = 8'(BASE); #1; chk("R2 csr reset", rdata_w, 32'd0); @(negedge clk);
        addr = ofs_w_cmp; #1; chk("R2 cmp reset wide", rdata_w, 32'hFFFF_FFFF); @(negedge clk);
        addr = ofs_n_cmp; #1; chk("R2 cmp reset narrow", rdata_n, 32'h0000_FFFF); @(negedge clk);
        idle(40);
        addr = ofs_w_cnt; #1; chk("R2 stopped after reset", rdata_w, 32'd0); @(negedge clk);

        // R1: unmapped offsets read zero, writes there are ignored
        wr(1, 8'h04, 32'hFFFF_FFFF);
        rd_chk(1, 8'h04, "R1 unmapped read");
        rd_chk(1, 8'h12, "R1 gap between wide regs");
        addr = 8'(BASE); #1; chk("R1 csr untouched by unmapped write", rdata_w, 32'd0); @(negedge clk);

        // R11: plain control/status bits read back
        wr(1, 8'(BASE), 32'h0000_01A4);
        wr(0, 8'(BASE), 32'h0000_0043);
        addr = 8'(BASE); #1;
        chk("R11 wide csr readback", rdata_w, 32'h0000_01A4);
        chk("R11 narrow csr readback", rdata_n, 32'h0000_0043);
        @(negedge clk);

        // R10: compare masking
        wr(0, ofs_n_cmp, 32'h1234_5678);
        wr(1, ofs_w_cmp, 32'h1234_5678);
        addr = ofs_n_cmp; #1; chk("R10 narrow keeps low 16", rdata_n, 32'h0000_5678); @(negedge clk);
        addr = ofs_w_cmp; #1; chk("R10 wide keeps 32", rdata_w, 32'h1234_5678); @(negedge clk);

        // R3: other run bits do not start this channel
        wr(1, 8'(BASE), 32'h0000_0020);        // /8, irq enable
        wr(1, ofs_w_cmp, 32'd5);
        wr(1, 8'd0, 32'h0000_000D);
        idle(60);
        rd_chk(1, ofs_w_cnt, "R3 stopped with other bits set");
        rd_chk(1, 8'd0, "R3 run reg stores all bits");

        // R4/R5: start, count, match, flag, irq
        wr(1, 8'd0, 32'h0000_0002);
        idle(17);
        rd_chk(1, ofs_w_cnt, "R4 counting on ticks");
        idle(40);
        rd_chk(1, 8'(BASE), "R5 match flag after period");
        chk("R8 irq raised on match", {31'd0, irq_w}, 32'd1);
        // R6: write one keeps, write zero clears
        wr(1, 8'(BASE), 32'h0000_8020);
        rd_chk(1, 8'(BASE), "R6 write one keeps flag");
        wr(1, 8'(BASE), 32'h0000_0020);
        #1; chk("R8 irq low after clear", {31'd0, irq_w}, {31'd0, m_csr[1][15]});
        rd_chk(1, 8'(BASE), "R6 flag cleared");

        // R9: delayed counter write, old value visible meanwhile
        wr(1, ofs_w_cnt, 32'hFFFF_FFFD);
        rd_chk(1, ofs_w_cnt, "R9 old value right after write");
        idle(7);
        rd_chk(1, ofs_w_cnt, "R9 still pending or landed per ticks");
        idle(20);
        rd_chk(1, ofs_w_cnt, "R9 landed");
        // R7: compare below count -> wrap, bit 14, no match flag yet
        idle(16);
        rd_chk(1, 8'(BASE), "R7 wrap bit without match");
        idle(48);
        rd_chk(1, 8'(BASE), "R7 match on the next pass");
        wr(1, 8'(BASE), 32'h0000_0000);
        rd_chk(1, 8'(BASE), "R8 csr zero clears flags and enable");

        // R9: load happens while stopped
        wr(1, 8'd0, 32'h0000_0000);
        wr(1, ofs_w_cnt, 32'd77);
        idle(30);
        addr = ofs_w_cnt; #1; chk("R9 load while stopped", rdata_w, 32'd77); @(negedge clk);

        // narrow variant at /512: flag bit 7 and irq
        wr(0, ofs_n_cmp, 32'd2);
        wr(0, 8'd0, 32'h0000_0002);
        idle(1700);
        addr = 8'(BASE); #1;
        chk("R6 narrow flag at bit 7", rdata_n & 32'h80, 32'h80);
        chk("R4 narrow /512 flag vs model", rdata_n, f_read(0, 8'(BASE)));
        @(negedge clk);
        wr(0, 8'(BASE), 32'h0000_0003);
        rd_chk(0, 8'(BASE), "R6 narrow clear");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int v;
            int op;
            v  = int'($urandom % 2);
            op = int'($urandom % 8);
            case (op)
                0: wr(v, 8'(BASE), (($urandom & 32'h0000_FFFC) | ($urandom % 2)));
                1: wr(v, 8'(BASE + 2 * f_stride(v)),
                      ($urandom % 2) ? ($urandom % 41) : (v ? f_max(v) - ($urandom % 4) : $urandom));
                2: wr(v, 8'(BASE + f_stride(v)),
                      ($urandom % 2) ? ($urandom % 41) : (f_max(v) - ($urandom % 3)));
                3: wr(v, 8'd0, (($urandom % 4) == 0) ? ($urandom & 32'hD) : ($urandom | 32'h2));
                default: begin
                    logic [7:0] a;
                    case ($urandom % 5)
                        0: a = 8'd0;
                        1: a = 8'(BASE);
                        2: a = 8'(BASE + f_stride(v));
                        3: a = 8'(BASE + 2 * f_stride(v));
                        default: a = 8'($urandom);
                    endcase
                    rd_chk(v, a, tag_of(v, a));
                    idle(int'($urandom % 12));
                end
            endcase
        end
        r = f_read(1, 8'(BASE));
        addr = 8'(BASE); #1; chk("R6 final wide csr", rdata_w, r); @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule